// File: doc/BRIEF.md
# Self-synchronizing line scrambler pair

This block holds a transmit-side scrambler and a receive-side descrambler for a serial link whose transceiver moves 80 line bits per clock. Each scrambled line bit is the data bit XORed with two earlier line bits. Those bits sit 71 and 79 places back in the serial stream, which is history positions 70 and 78 of a 79-bit record of past line bits. The descrambler applies the same XOR to the received line bits and recovers the data. It needs no shared seed. Once it has seen 79 correct line bits, its history matches the transmitter's history, and every later output bit is correct.

The serial recursion is unrolled across the word. Bit 0 is the first bit on the line and bit 79 the last. A line bit produced early in a word feeds the taps of later bits in the same word. The 79 most recent line bits of each accepted word are kept in a register for the next word. Both paths take one clock cycle and flag their results with a valid strobe. A cycle with the input valid low leaves the history and the outputs unchanged.

Top module: `ssx_scrambler_top`

## Requirements
- R1: While `rst` is high at a clock edge, both histories clear to zero, both output words clear to zero, and both output valids go low.
- R2: Scrambled line bit j of a word equals data bit j XOR the line bits 71 and 79 positions earlier in the serial stream, with bit 0 sent first. Right after reset, data with only bit 0 set gives line bits 0, 71 and 79 (80'h8080_0000_0000_0000_0001). Data with only bit 1 set gives line bits 1 and 72. Data with only bit 8 set gives line bits 8 and 79.
- R3: Line bits from one word feed the taps of the next accepted word. After reset, data bit 9 alone followed by an all-zero word gives a second line word with bits 0, 8 and 71 set.
- R4: A cycle with the input valid low changes no history. The output word holds its value and the output valid is low in the following cycle.
- R5: Descrambled data bit j equals received line bit j XOR the received line bits 71 and 79 positions earlier. Right after reset, a received word with only bit 0 set gives data bits 0, 71 and 79.
- R6: When both sides start from reset, passing the scrambler's line words to the descrambler recovers the original data exactly, from the first word on, even with idle cycles in between.
- R7: If the descrambler starts from a history that does not match the transmitter's, every data bit from stream bit 79 onward is still correct.
- R8: One flipped line bit corrupts exactly three recovered data bits, at offsets 0, 71 and 79 from the flipped bit.
- R9: An output valid rises in the cycle after its input valid is sampled high. The output word it marks belongs to that input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_valid | input | 1 | Transmit data word is present |
| tx_data | input | 80 | Transmit data word, bit 0 first on the line |
| tx_line_valid | output | 1 | Scrambled line word is valid |
| tx_line | output | 80 | Scrambled line word |
| rx_valid | input | 1 | Received line word is present |
| rx_line | input | 80 | Received line word, bit 0 first |
| rx_data_valid | output | 1 | Recovered data word is valid |
| rx_data | output | 80 | Recovered data word |

## Verification
The bench uses the default parameters: an 80-bit word, a 79-bit history and taps 70 and 78. With these values the far tap of bit 79 falls inside the same word. Tap products also cross one word boundary and reach the next word. Both cases are checked against a bit-serial reference model. The error-spread test needs these sizes: a flipped bit at position 30 spreads into the following word at bits 21 and 29. The resynchronization test relies on bit 79 of the first word being the first bit the descrambler is bound to get right.

// File: rtl/ssx_pkg.sv
package ssx_pkg;

    localparam int unsigned LINE_W   = 80;
    localparam int unsigned HIST_LEN = 79;
    localparam int unsigned TAP_NEAR = 70;
    localparam int unsigned TAP_FAR  = 78;

    typedef enum logic {
        MIX_SCRAMBLE   = 1'b0,
        MIX_DESCRAMBLE = 1'b1
    } mix_mode_e;

    // Index into the joined stream {word, history} for the tap of a given bit.
    // Stream position hist_len-1-i holds history bit i; position hist_len+j holds word bit j.
    function automatic int unsigned tap_src(input int unsigned hist_len,
                                            input int unsigned bitpos,
                                            input int unsigned tap);
        return hist_len + bitpos - 1 - tap;
    endfunction

endpackage

// File: rtl/ssx_hist_reg.sv
module ssx_hist_reg #(
    parameter int unsigned W    = ssx_pkg::LINE_W,
    parameter int unsigned HIST = ssx_pkg::HIST_LEN,
    localparam int unsigned SW  = HIST + W
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            en,
    input  logic [SW-1:0]   strm,
    output logic [HIST-1:0] hist
);

    logic [HIST-1:0] hist_nxt;

    // newest stream bit becomes history bit 0
    for (genvar i = 0; i < HIST; i++) begin : g_take
        assign hist_nxt[i] = strm[SW-1-i];
    end

    always_ff @(posedge clk) begin
        if (rst)     hist <= '0;
        else if (en) hist <= hist_nxt;
    end

    a_r1_hist_cleared: assert property (@(posedge clk) rst |=> hist == '0);
    a_r4_hist_idle_hold: assert property (@(posedge clk) disable iff (rst)
        !en |=> $stable(hist));

endmodule

// File: rtl/ssx_mix_core.sv
module ssx_mix_core #(
    parameter int unsigned W    = ssx_pkg::LINE_W,
    parameter int unsigned HIST = ssx_pkg::HIST_LEN,
    parameter int unsigned TA   = ssx_pkg::TAP_NEAR,
    parameter int unsigned TB   = ssx_pkg::TAP_FAR,
    parameter ssx_pkg::mix_mode_e MODE = ssx_pkg::MIX_SCRAMBLE,
    localparam int unsigned SW  = HIST + W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         in_valid,
    input  logic [W-1:0] din,
    output logic         out_valid,
    output logic [W-1:0] dout
);
    import ssx_pkg::*;

    logic [HIST-1:0] hist;
    logic [SW-1:0]   strm;
    logic [W-1:0]    mixed;

    if (MODE == MIX_SCRAMBLE) begin : g_scr
        // feedback from own output: bit j sees line bits produced earlier in the word
        always_comb begin : scr_unroll
            logic [SW-1:0] s;
            logic          b;
            s = '0;
            for (int i = 0; i < HIST; i++) s[HIST-1-i] = hist[i];
            for (int j = 0; j < W; j++) begin
                b = din[j] ^ s[tap_src(HIST, j, TA)] ^ s[tap_src(HIST, j, TB)];
                s[HIST+j] = b;
            end
            strm  = s;
            mixed = s[SW-1:HIST];
        end
    end else begin : g_dsc
        // feed-forward from received line bits only
        always_comb begin : dsc_unroll
            logic [SW-1:0] s;
            s = '0;
            for (int i = 0; i < HIST; i++) s[HIST-1-i] = hist[i];
            s[SW-1:HIST] = din;
            for (int j = 0; j < W; j++) begin
                mixed[j] = din[j] ^ s[tap_src(HIST, j, TA)] ^ s[tap_src(HIST, j, TB)];
            end
            strm = s;
        end
    end

    ssx_hist_reg #(.W(W), .HIST(HIST)) hist_i (
        .clk  (clk),
        .rst  (rst),
        .en   (in_valid),
        .strm (strm),
        .hist (hist)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            dout      <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) dout <= mixed;
        end
    end

    a_r9_valid_follows: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    a_r9_valid_drops: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);
    a_r4_word_idle_hold: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(dout));

    if (MODE == MIX_SCRAMBLE) begin : g_a_scr
        // R3: the history's newest bit is the last line bit sent
        a_r3_newest_line_bit: assert property (@(posedge clk) disable iff (rst)
            in_valid |=> hist[0] == dout[W-1]);
    end else begin : g_a_dsc
        a_r3_newest_rx_bit: assert property (@(posedge clk) disable iff (rst)
            in_valid |=> hist[0] == $past(din[W-1]));
    end

endmodule

// File: rtl/ssx_scrambler_top.sv
module ssx_scrambler_top #(
    parameter int unsigned W    = ssx_pkg::LINE_W,
    parameter int unsigned HIST = ssx_pkg::HIST_LEN,
    parameter int unsigned TA   = ssx_pkg::TAP_NEAR,
    parameter int unsigned TB   = ssx_pkg::TAP_FAR
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tx_valid,
    input  logic [W-1:0] tx_data,
    output logic         tx_line_valid,
    output logic [W-1:0] tx_line,
    input  logic         rx_valid,
    input  logic [W-1:0] rx_line,
    output logic         rx_data_valid,
    output logic [W-1:0] rx_data
);

    ssx_mix_core #(.W(W), .HIST(HIST), .TA(TA), .TB(TB),
                   .MODE(ssx_pkg::MIX_SCRAMBLE)) tx_core_i (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (tx_valid),
        .din       (tx_data),
        .out_valid (tx_line_valid),
        .dout      (tx_line)
    );

    ssx_mix_core #(.W(W), .HIST(HIST), .TA(TA), .TB(TB),
                   .MODE(ssx_pkg::MIX_DESCRAMBLE)) rx_core_i (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (rx_valid),
        .din       (rx_line),
        .out_valid (rx_data_valid),
        .dout      (rx_data)
    );

    a_r1_reset_outputs: assert property (@(posedge clk)
        rst |=> (!tx_line_valid && !rx_data_valid && tx_line == '0 && rx_data == '0));

endmodule

// File: tb/ssx_scrambler_top_tb_top.sv
module ssx_scrambler_top_tb_top;

    localparam int W = 80;
    localparam int H = 79;
    localparam int CLK_PERIOD = 10;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         tx_valid = 1'b0;
    logic [W-1:0] tx_data = '0;
    logic         tx_line_valid;
    logic [W-1:0] tx_line;
    logic         rx_valid = 1'b0;
    logic [W-1:0] rx_line = '0;
    logic         rx_data_valid;
    logic [W-1:0] rx_data;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ssx_scrambler_top dut_i (
        .clk(clk), .rst(rst),
        .tx_valid(tx_valid), .tx_data(tx_data),
        .tx_line_valid(tx_line_valid), .tx_line(tx_line),
        .rx_valid(rx_valid), .rx_line(rx_line),
        .rx_data_valid(rx_data_valid), .rx_data(rx_data)
    );

    // R2 table: data word from reset and the expected first line word
    localparam logic [W-1:0] VEC_D [5] = '{
        80'h0,
        80'h0000_0000_0000_0000_0001,
        80'h0000_0000_0000_0000_0002,
        80'h0000_0000_0000_0000_0100,
        80'h0000_0000_0000_0000_0200
    };
    localparam logic [W-1:0] VEC_L [5] = '{
        80'h0,
        80'h8080_0000_0000_0000_0001,
        80'h0100_0000_0000_0000_0002,
        80'h8000_0000_0000_0000_0100,
        80'h0000_0000_0000_0000_0200
    };

    // bit-serial reference history: bit i is the line bit sent i+1 places earlier
    logic [H-1:0] mh;
    logic [W-1:0] D [4];
    logic [W-1:0] L [4];

    task automatic model_word(input logic [W-1:0] d, output logic [W-1:0] l);
        logic b;
        for (int j = 0; j < W; j++) begin
            b = d[j] ^ mh[70] ^ mh[78];
            l[j] = b;
            mh = {mh[H-2:0], b};
        end
    endtask

    function automatic logic [W-1:0] pat(input int k);
        logic [63:0] lo;
        lo = 64'hD1B5_4A32_D192_ED03 * 64'(k + 3);
        return {16'(k * 40503 + 7), lo};
    endfunction

    task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cyc(input logic tv, input logic [W-1:0] td,
                       input logic rv, input logic [W-1:0] rl);
        tx_valid = tv; tx_data = td; rx_valid = rv; rx_line = rl;
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        cyc(0, '0, 0, '0);
        cyc(0, '0, 0, '0);
        rst = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        logic [W-1:0] held;
        logic [W-1:0] tmp;
        @(negedge clk);
        do_reset();

        // R1: reset state
        check("R1 tx_line", tx_line, '0);
        check("R1 rx_data", rx_data, '0);
        check("R1 valids", {78'd0, tx_line_valid, rx_data_valid}, '0);

        // R2 table walk, each row from reset
        for (int k = 0; k < 5; k++) begin
            do_reset();
            cyc(1, VEC_D[k], 0, '0);
            check("R2 table", tx_line, VEC_L[k]);
            check("R9 valid", {79'd0, tx_line_valid}, 80'd1);
            if (k == 4) begin
                // R3: bit 9 reaches the next word at bits 0 and 8, then bit 71
                cyc(1, '0, 0, '0);
                check("R3 carry", tx_line, 80'h0080_0000_0000_0000_0101);
            end
        end

        // R5: descrambler from reset
        do_reset();
        cyc(0, '0, 1, 80'h1);
        check("R5 descramble", rx_data, 80'h8080_0000_0000_0000_0001);
        check("R9 rx valid", {79'd0, rx_data_valid}, 80'd1);

        // R2/R3/R4: multiword scrambling against serial model with an idle gap
        do_reset();
        mh = '0;
        for (int k = 0; k < 4; k++) begin
            D[k] = pat(k);
            model_word(D[k], L[k]);
            cyc(1, D[k], 0, '0);
            check("R3 multiword", tx_line, L[k]);
            if (k == 1) begin
                held = tx_line;
                cyc(0, pat(99), 0, '0);
                check("R4 hold word", tx_line, held);
                check("R4 valid low", {79'd0, tx_line_valid}, '0);
            end
        end

        // R6: loopback through the descrambler with an idle gap
        for (int k = 0; k < 4; k++) begin
            cyc(0, '0, 1, L[k]);
            check("R6 loopback", rx_data, D[k]);
            if (k == 2) begin
                cyc(0, '0, 0, ~L[k]);
                check("R4 rx valid low", {79'd0, rx_data_valid}, '0);
            end
        end

        // R7: transmitter history mismatched with receiver
        do_reset();
        mh = 79'h5A5A_1234_ABCD_0F0F_7E3C;
        for (int k = 0; k < 4; k++) begin
            D[k] = pat(k + 10);
            model_word(D[k], L[k]);
        end
        cyc(0, '0, 1, L[0]);
        check("R7 bit79", {79'd0, rx_data[79]}, {79'd0, D[0][79]});
        for (int k = 1; k < 4; k++) begin
            cyc(0, '0, 1, L[k]);
            check("R7 resync", rx_data, D[k]);
        end

        // R8: single line error at word 1 bit 30
        do_reset();
        mh = '0;
        for (int k = 0; k < 4; k++) begin
            D[k] = pat(k + 20);
            model_word(D[k], L[k]);
        end
        L[1][30] = ~L[1][30];
        for (int k = 0; k < 4; k++) begin
            cyc(0, '0, 1, L[k]);
            tmp = rx_data ^ D[k];
            case (k)
                1: check("R8 err word1", tmp, 80'h1 << 30);
                2: check("R8 err word2", tmp, (80'h1 << 21) | (80'h1 << 29));
                default: check("R8 clean", tmp, '0);
            endcase
        end

        // R1: reset mid-stream clears outputs
        rst = 1'b1;
        cyc(1, pat(5), 1, pat(6));
        rst = 1'b0;
        check("R1 mid reset", tx_line | rx_data, '0);

        finish_run();
    end

endmodule